// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Controller

This block collects a bank of interrupt sources, by default 32, and turns them into two request lines and one wake line for a processor. Each source has its own trigger mode. The mode can be rising edge, falling edge, either edge, active-high level or active-low level, or the source can be switched off. Edges are caught in two sticky latch vectors, one for rising edges and one for falling edges. Each latched bit stays set until software clears it. A level source is pending only while its input sits at the active level.

Software drives the block through a flat word-addressed register port (address, write data, write strobe, combinational read data). Every per-source control vector has three addresses: one reads it back, one sets bits and one clears bits. Software can therefore change one source without a read-modify-write. A pending source that is unmasked reaches request 0 or request 1, as its route bit selects. A pending source whose wake bit is set reaches the wake line. Two status words show, for each request line, which routed sources are currently unmasked and pending.

Input synchronisation, priority selection and dispatch belong to the logic around the block.

Top module: `intc_bank`

## Requirements
- R1: The trigger mode of source i is the triple {mode2[i],mode1[i],mode0[i]}. The codes are: 3'b001 rising edge, 3'b010 falling edge, 3'b011 either edge, 3'b101 input high, 3'b110 input low, and 3'b000 off. An edge-mode source is pending while its matching edge latch bit is set.
- R2: Codes 3'b100 and 3'b111 act as off: the source is never pending and its edge latches never capture.
- R3: The control vectors are mode0 (base 0), mode1 (base 4), mode2 (base 8), mask (base 12), wake (base 16), route (base 20) and enable (base 24). Each is read at base+0, set at base+1 and cleared at base+2. A write changes only the bit positions written as 1.
- R4: A rising edge of an enabled input in mode 001 or 011 sets its bit in the rising latch, read at address 28. A falling edge in mode 010 or 011 sets its bit in the falling latch, read at address 32. The bits hold until a 1 is written to the same position at address 30 (rising) or address 34 (falling).
- R5: A source whose route bit is 1 reaches request 0, and a source whose route bit is 0 reaches request 1. No source reaches both.
- R6: Status word 0 (address 36) is pending AND mask AND route. Status word 1 (address 40) is pending AND mask AND NOT route.
- R7: req0_o and req1_o are the registered OR of status word 0 and status word 1. They follow one clock after the status words. A source drives a request only while its mask bit is 1. wake_o is the registered OR of pending AND wake.
- R8: After reset the mode, mask and wake vectors, both edge latches and the test word read 0. The route and enable vectors read all ones. All three outputs are 0.
- R9: While the test word (read and written at address 44) is nonzero, req0_o, req1_o and wake_o are held at 0. The status words still report.
- R10: A source whose enable bit is 0 is never pending and captures no edges.
- R11: Level-mode sources are not latched: the source stops being pending once its input leaves the active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 6 | Register word address |
| wdata | input | N | Write data |
| we | input | 1 | Write strobe, one write per cycle |
| rdata | output | N | Read data for the current address (combinational) |
| src_i | input | N | Source inputs, already synchronous to clk |
| req0_o | output | 1 | Interrupt request 0 |
| req1_o | output | 1 | Interrupt request 1 |
| wake_o | output | 1 | Wake request |

## Verification
The embedded properties check on every cycle:
- the set/clear write semantics of each control vector;
- that new latch bits appear only on a qualifying edge, and that latch bits fall only on a clear write;
- that the two status words never share a source;
- that off and reserved codes never produce a pending source;
- that a zero mask, a zero wake vector or a nonzero test word silences the matching outputs.

Only the bench's scenarios can show that each of the eight codes gives the right pending value through a rise, a fall and a latch clear, on every lane and for both route settings. The same holds for the reset contents and the effect of the enable bit.

// File: rtl/intc_pkg.sv
// Package: register map and trigger codes shared by the interrupt bank.
// Assumes a word address of ADDR_W bits. Control vector g sits at g*4 (read),
// g*4+1 (set) and g*4+2 (clear).
package intc_pkg;
    localparam int ADDR_W   = 6;
    localparam int NUM_CTL  = 7;
    localparam int CTL_MODE0 = 0;
    localparam int CTL_MODE1 = 1;
    localparam int CTL_MODE2 = 2;
    localparam int CTL_MASK  = 3;
    localparam int CTL_WAKE  = 4;
    localparam int CTL_ROUTE = 5;
    localparam int CTL_EN    = 6;
    localparam int OFS_RD  = 0;
    localparam int OFS_SET = 1;
    localparam int OFS_CLR = 2;
    localparam int A_RISE_RD  = 28;
    localparam int A_RISE_CLR = 30;
    localparam int A_FALL_RD  = 32;
    localparam int A_FALL_CLR = 34;
    localparam int A_STAT0    = 36;
    localparam int A_STAT1    = 40;
    localparam int A_TEST     = 44;

    typedef enum logic [2:0] {
        TRG_OFF  = 3'b000,
        TRG_RISE = 3'b001,
        TRG_FALL = 3'b010,
        TRG_BOTH = 3'b011,
        TRG_RSV4 = 3'b100,
        TRG_HIGH = 3'b101,
        TRG_LOW  = 3'b110,
        TRG_RSV7 = 3'b111
    } trig_e;
endpackage

// File: rtl/intc_sc_reg.sv
// Module: one control vector with set, clear and read addresses.
// A write to BASE+1 ORs in wdata and a write to BASE+2 removes the bits of
// wdata. Reads are decoded by the parent. Assumes one write per cycle.
module intc_sc_reg
    import intc_pkg::*;
#(
    parameter int W        = 32,
    parameter int BASE     = 0,
    parameter bit RST_ONES = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      q
);
    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(BASE + OFS_SET);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(BASE + OFS_CLR);
    localparam logic [W-1:0]      RST_V = RST_ONES ? '1 : '0;

    // Apply set or clear writes bit by bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                    q <= RST_V;
        else if (we && addr == SET_A)  q <= q | wdata;
        else if (we && addr == CLR_A)  q <= q & ~wdata;
    end

    // R3
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == SET_A) |=> ((q & $past(wdata)) == $past(wdata)));
    // R3
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == CLR_A) |=> ((q & $past(wdata)) == '0));
    // R3
    keep_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (addr == SET_A || addr == CLR_A)) |=> (((q ^ $past(q)) & ~$past(wdata)) == '0));
endmodule

// File: rtl/intc_edge_latch.sv
// Module: sticky edge latch vector. Bits set on ev_i and drop only where a
// clear write carries a 1. When a set and a clear hit the same cycle, the set
// wins so that no edge is lost.
module intc_edge_latch #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev_i,
    input  logic         clr_i,
    input  logic [W-1:0] clr_bits_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] clr_mask;

    // Select which bits a clear write removes this cycle.
    always_comb clr_mask = clr_i ? clr_bits_i : '0;

    // Hold captured edges until software clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= (q_o & ~clr_mask) | ev_i;
    end

    // R4
    set_only_by_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q_o & ~$past(q_o) & ~$past(ev_i)) == '0));
    // R4
    sticky_without_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (($past(q_o) & ~q_o) == '0));
endmodule

// File: rtl/intc_trig_decode.sv
// Module: per-source trigger decode. Yields the latch capture events and the
// pending vector from the mode triple, the input and its previous value.
// Assumes src_i is already synchronous. Reserved codes behave as off.
module intc_trig_decode
    import intc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] src_q_i,
    input  logic [W-1:0] mode0_i,
    input  logic [W-1:0] mode1_i,
    input  logic [W-1:0] mode2_i,
    input  logic [W-1:0] en_i,
    input  logic [W-1:0] rise_q_i,
    input  logic [W-1:0] fall_q_i,
    output logic [W-1:0] rise_ev_o,
    output logic [W-1:0] fall_ev_o,
    output logic [W-1:0] pend_o
);
    for (genvar i = 0; i < W; i++) begin : g_lane
        trig_e mode;
        logic  rise_mode, fall_mode, raw;

        // Form the lane's mode code and its edge sensitivities.
        always_comb begin
            mode      = trig_e'({mode2_i[i], mode1_i[i], mode0_i[i]});
            rise_mode = (mode == TRG_RISE) || (mode == TRG_BOTH);
            fall_mode = (mode == TRG_FALL) || (mode == TRG_BOTH);
        end

        // Qualify edges of the lane input with mode and enable.
        always_comb begin
            rise_ev_o[i] = en_i[i] & rise_mode &  src_i[i] & ~src_q_i[i];
            fall_ev_o[i] = en_i[i] & fall_mode & ~src_i[i] &  src_q_i[i];
        end

        // Pick the pending source for the lane's mode.
        always_comb begin
            case (mode)
                TRG_RISE: raw = rise_q_i[i];
                TRG_FALL: raw = fall_q_i[i];
                TRG_BOTH: raw = rise_q_i[i] | fall_q_i[i];
                TRG_HIGH: raw = src_i[i];
                TRG_LOW:  raw = ~src_i[i];
                default:  raw = 1'b0;
            endcase
            pend_o[i] = raw & en_i[i];
        end
    end
endmodule

// File: rtl/intc_bank.sv
// Module: top of the interrupt bank. It holds seven set/clear control vectors,
// the two edge latches and the test word. It decodes pending sources, routes
// them to two registered request outputs and a registered wake output, and
// serves combinational read data. Assumes synchronous inputs and one register
// access per cycle.
module intc_bank
    import intc_pkg::*;
#(
    parameter int N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wdata,
    input  logic              we,
    output logic [N-1:0]      rdata,
    input  logic [N-1:0]      src_i,
    output logic              req0_o,
    output logic              req1_o,
    output logic              wake_o
);
    logic [N-1:0] ctl [NUM_CTL];
    logic [N-1:0] src_q, rise_q, fall_q, rise_ev, fall_ev, pend;
    logic [N-1:0] stat0, stat1, wake_v, test_q;
    logic         quiet;

    for (genvar g = 0; g < NUM_CTL; g++) begin : g_ctl
        intc_sc_reg #(
            .W(N), .BASE(g * 4), .RST_ONES(g >= CTL_ROUTE)
        ) u_reg (
            .clk(clk), .rst_n(rst_n), .we(we), .addr(addr),
            .wdata(wdata), .q(ctl[g])
        );
    end

    // Keep last cycle's inputs for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_i;
    end

    intc_trig_decode #(.W(N)) u_dec (
        .src_i(src_i), .src_q_i(src_q),
        .mode0_i(ctl[CTL_MODE0]), .mode1_i(ctl[CTL_MODE1]), .mode2_i(ctl[CTL_MODE2]),
        .en_i(ctl[CTL_EN]), .rise_q_i(rise_q), .fall_q_i(fall_q),
        .rise_ev_o(rise_ev), .fall_ev_o(fall_ev), .pend_o(pend)
    );

    intc_edge_latch #(.W(N)) u_rise (
        .clk(clk), .rst_n(rst_n), .ev_i(rise_ev),
        .clr_i(we && addr == ADDR_W'(A_RISE_CLR)), .clr_bits_i(wdata), .q_o(rise_q)
    );

    intc_edge_latch #(.W(N)) u_fall (
        .clk(clk), .rst_n(rst_n), .ev_i(fall_ev),
        .clr_i(we && addr == ADDR_W'(A_FALL_CLR)), .clr_bits_i(wdata), .q_o(fall_q)
    );

    // Store the test word written at its own address.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  test_q <= '0;
        else if (we && addr == ADDR_W'(A_TEST))      test_q <= wdata;
    end

    // Split unmasked pending sources by route and gather wake sources.
    always_comb begin
        stat0  = pend & ctl[CTL_MASK] &  ctl[CTL_ROUTE];
        stat1  = pend & ctl[CTL_MASK] & ~ctl[CTL_ROUTE];
        wake_v = pend & ctl[CTL_WAKE];
        quiet  = (test_q != '0);
    end

    // Register the request and wake outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req0_o <= 1'b0;
            req1_o <= 1'b0;
            wake_o <= 1'b0;
        end else begin
            req0_o <= !quiet && (|stat0);
            req1_o <= !quiet && (|stat1);
            wake_o <= !quiet && (|wake_v);
        end
    end

    // Serve read data for the current address.
    always_comb begin
        rdata = '0;
        for (int g = 0; g < NUM_CTL; g++)
            if (addr == ADDR_W'(g * 4 + OFS_RD)) rdata = ctl[g];
        case (addr)
            ADDR_W'(A_RISE_RD): rdata = rise_q;
            ADDR_W'(A_FALL_RD): rdata = fall_q;
            ADDR_W'(A_STAT0):   rdata = stat0;
            ADDR_W'(A_STAT1):   rdata = stat1;
            ADDR_W'(A_TEST):    rdata = test_q;
            default: ;
        endcase
    end

    // R5
    route_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat0 & stat1) == '0);
    // R2
    reserved_never_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & ((~ctl[CTL_MODE2] & ~ctl[CTL_MODE1] & ~ctl[CTL_MODE0]) |
                 ( ctl[CTL_MODE2] & ~ctl[CTL_MODE1] & ~ctl[CTL_MODE0]) |
                 ( ctl[CTL_MODE2] &  ctl[CTL_MODE1] &  ctl[CTL_MODE0]))) == '0);
    // R7
    mask_silences_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[CTL_MASK] == '0) |=> (!req0_o && !req1_o));
    // R7
    wake_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[CTL_WAKE] == '0) |=> !wake_o);
    // R9
    test_quiets_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_q != '0) |=> (!req0_o && !req1_o && !wake_o));
    // R10
    disabled_not_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & ~ctl[CTL_EN]) == '0);
endmodule

// File: tb/intc_bank_test.sv
// Bench: sweeps every trigger code over all 32 lanes, with every mask and wake
// combination and both route settings, plus reset, set/clear, test word and
// enable scenarios.
module intc_bank_test;
    import intc_pkg::*;
    localparam int N = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [N-1:0]      wdata = '0;
    logic              we = 1'b0;
    logic [N-1:0]      rdata;
    logic [N-1:0]      src = '0;
    logic              req0, req1, wake;
    int                n_chk = 0;
    int                n_bad = 0;
    bit                done = 1'b0;

    always #4 clk = ~clk;

    intc_bank #(.N(N)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
        .rdata(rdata), .src_i(src), .req0_o(req0), .req1_o(req1), .wake_o(wake)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [N-1:0] d);
        @(negedge clk);
        addr = ADDR_W'(a); wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input int a, output logic [N-1:0] d);
        @(negedge clk);
        addr = ADDR_W'(a);
        #1 d = rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    function automatic bit exp_pend(input int m, input int phase);
        case (phase)
            0: return m == 6;
            1: return (m == 1) || (m == 3) || (m == 5);
            2: return (m == 1) || (m == 2) || (m == 3) || (m == 6);
            default: return m == 6;
        endcase
    endfunction

    task automatic check_outs(input string tag, input int lane, input bit p,
                              input bit mk, input bit wk, input bit rt);
        logic [N-1:0] v;
        logic [N-1:0] bitv;
        bitv = N'(1) << lane;
        rd(A_STAT0, v); chk({tag, " R6 stat0"}, v, (p && mk && rt) ? bitv : '0);
        rd(A_STAT1, v); chk({tag, " R6 stat1"}, v, (p && mk && !rt) ? bitv : '0);
        chk({tag, " R5 req0"}, N'(req0), N'(p && mk && rt));
        chk({tag, " R5 req1"}, N'(req1), N'(p && mk && !rt));
        chk({tag, " R7 wake"}, N'(wake), N'(p && wk));
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8 reset contents
        for (int g = 0; g < NUM_CTL; g++) begin
            rd(g * 4, v);
            chk("R8 control reset", v, (g >= CTL_ROUTE) ? '1 : '0);
        end
        rd(A_RISE_RD, v); chk("R8 rise reset", v, '0);
        rd(A_FALL_RD, v); chk("R8 fall reset", v, '0);
        rd(A_TEST, v);    chk("R8 test reset", v, '0);
        chk("R8 outputs reset", N'({req0, req1, wake}), '0);

        // R3 set and clear touch only bits written as 1
        wr(CTL_MASK * 4 + OFS_SET, 32'h0000_00A5);
        wr(CTL_MASK * 4 + OFS_SET, 32'h0000_0100);
        rd(CTL_MASK * 4, v); chk("R3 set", v, 32'h0000_01A5);
        wr(CTL_MASK * 4 + OFS_CLR, 32'h0000_000F);
        rd(CTL_MASK * 4, v); chk("R3 clear", v, 32'h0000_01A0);
        wr(CTL_MASK * 4 + OFS_CLR, '1);

        // R1 R2 R4 R11 sweep: codes x lanes x mask x wake x route
        for (int rt = 0; rt < 2; rt++) begin
            for (int m = 0; m < 8; m++) begin
                for (int mw = 0; mw < 4; mw++) begin
                    int lane;
                    bit mk, wk;
                    string tag;
                    lane = m * 4 + mw;
                    mk = mw[1]; wk = mw[0];
                    tag = (m == 4 || m == 7) ? "R2" : ((m == 5 || m == 6) ? "R11" : "R1");
                    src = '0;
                    for (int g = 0; g <= CTL_WAKE; g++) wr(g * 4 + OFS_CLR, '1);
                    wr(CTL_ROUTE * 4 + (rt == 1 ? OFS_SET : OFS_CLR), '1);
                    wr(A_RISE_CLR, '1);
                    wr(A_FALL_CLR, '1);
                    if (m[0]) wr(CTL_MODE0 * 4 + OFS_SET, N'(1) << lane);
                    if (m[1]) wr(CTL_MODE1 * 4 + OFS_SET, N'(1) << lane);
                    if (m[2]) wr(CTL_MODE2 * 4 + OFS_SET, N'(1) << lane);
                    if (mk)   wr(CTL_MASK  * 4 + OFS_SET, N'(1) << lane);
                    if (wk)   wr(CTL_WAKE  * 4 + OFS_SET, N'(1) << lane);
                    settle();
                    check_outs({tag, " idle"}, lane, exp_pend(m, 0), mk, wk, rt[0]);
                    @(negedge clk); src[lane] = 1'b1;
                    settle();
                    check_outs({tag, " high"}, lane, exp_pend(m, 1), mk, wk, rt[0]);
                    @(negedge clk); src[lane] = 1'b0;
                    settle();
                    check_outs({tag, " low"}, lane, exp_pend(m, 2), mk, wk, rt[0]);
                    rd(A_RISE_RD, v);
                    chk("R4 rise latch", v, (m == 1 || m == 3) ? (N'(1) << lane) : '0);
                    rd(A_FALL_RD, v);
                    chk("R4 fall latch", v, (m == 2 || m == 3) ? (N'(1) << lane) : '0);
                    wr(A_RISE_CLR, '1);
                    wr(A_FALL_CLR, '1);
                    settle();
                    check_outs("R4 cleared", lane, exp_pend(m, 3), mk, wk, rt[0]);
                end
            end
        end

        // R9 test word silences outputs; lane 3 high level, mask, wake, route 0
        src = '0;
        for (int g = 0; g <= CTL_WAKE; g++) wr(g * 4 + OFS_CLR, '1);
        wr(CTL_ROUTE * 4 + OFS_SET, '1);
        wr(CTL_MODE0 * 4 + OFS_SET, 32'h8);
        wr(CTL_MODE2 * 4 + OFS_SET, 32'h8);
        wr(CTL_MASK * 4 + OFS_SET, 32'h8);
        wr(CTL_WAKE * 4 + OFS_SET, 32'h8);
        @(negedge clk); src[3] = 1'b1;
        settle();
        chk("R9 active before", N'({req0, wake}), 2'b11);
        wr(A_TEST, 32'h1);
        settle();
        chk("R9 outputs held", N'({req0, req1, wake}), '0);
        rd(A_STAT0, v); chk("R9 status still reports", v, 32'h8);
        wr(A_TEST, 32'h0);
        settle();
        chk("R9 released", N'({req0, wake}), 2'b11);

        // R10 enable bit off suppresses pending, and edges are not captured
        wr(CTL_EN * 4 + OFS_CLR, 32'h8);
        settle();
        rd(A_STAT0, v); chk("R10 status", v, '0);
        chk("R10 outputs", N'({req0, req1, wake}), '0);
        wr(CTL_MODE2 * 4 + OFS_CLR, 32'h8);
        wr(CTL_MODE1 * 4 + OFS_SET, 32'h8);
        @(negedge clk); src[3] = 1'b0;
        settle();
        rd(A_FALL_RD, v); chk("R10 no capture", v, '0);
        wr(CTL_EN * 4 + OFS_SET, 32'h8);
        settle();
        rd(A_STAT0, v); chk("R10 reenabled no latch", v, '0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule